// File: doc/BRIEF.md
# Serial Channel Command and Mode Register Unit

This unit holds the control side of one channel of a multi-channel serial port. Software writes bytes to a small register window. A byte written to the command address carries four independent enable and disable bits in its low nibble and a command code in its high nibble. The unit applies both parts in a single cycle. It keeps the channel status byte and the receiver enable, and it passes holding-register writes to the transmit path only while the transmitter is ready.

Two mode bytes share one address. A pointer picks which of them an access reaches, and that pointer stays on the last entry after any access. The only way to bring it back to the first entry is a command. The receive path reports its events on a set-mask input. The unit sends one-cycle set and clear pulses to the shared interrupt status logic of its channel pair. Writes to the clock-select and auxiliary addresses are accepted and dropped.

All outputs are registered. The result of a write or read shows on the outputs in the cycle after the strobe.

Top module: `uart_chan_cmdreg`

## Requirements
- R1: After reset, `status_o`, `rx_en_o`, `mode_rdata_o`, `tx_stb_o`, `isr_set_o` and `isr_clr_o` are all zero, and the mode pointer selects entry 0.
- R2: In a command write (address 2), bit 0 turns the receiver on and bit 1 turns it off. Bit 1 is applied after bit 0, so setting both leaves the receiver off.
- R3: In a command write, bit 2 sets status bits 2 (transmitter ready) and 3 (transmitter empty) and pulses `isr_set_o[0]`. Bit 3 is applied afterwards: it clears both status bits and pulses `isr_clr_o[0]`. Status bits 2 and 3 always hold equal values.
- R4: Command code 2 (bits 7:4) turns the receiver off, clears status bit 0 (receiver ready) and pulses `isr_clr_o[1]`. The set and clear pulses for bits 1:0 are never high together.
- R5: Command code 3 clears status bits 3:2 and pulses `isr_clr_o[0]`. An enable bit in the same byte does not turn the transmitter back on.
- R6: Command code 4 clears status bits 7:4 (overrun, parity, framing, break) and leaves bits 3:0 as they are.
- R7: Command code 5 pulses `isr_clr_o[2]`, which clears the break bits of both channels of the pair. The status byte is unchanged.
- R8: Command code 0 and codes 6 to 15 change nothing beyond the effects of the low-nibble bits.
- R9: A mode access (address 0) reads or writes the entry the pointer selects and then sets the pointer to entry 1. Only command code 1 returns the pointer to 0. Read data appears on `mode_rdata_o` and holds until the next mode read.
- R10: A write to the holding address (address 3) gives a one-cycle `tx_stb_o` with the byte on `tx_data_o` only when status bit 2 was set before the write. Otherwise the byte is dropped.
- R11: Writes to address 1, address 4 and addresses 5 to 7, and reads of any address other than 0, change no output and no state.
- R12: `stat_set_i` bits 0, 1 and 4 to 7 are ORed into the status byte, and its bits 2 and 3 are ignored. A clear from a command in the same cycle takes precedence. `isr_set_o[1]` pulses when status bit 0 rises and `isr_set_o[2]` pulses when status bit 7 rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (ignored while wr_i is high) |
| addr_i | input | 3 | Register address: 0 mode, 1 clock select, 2 command, 3 holding, 4 auxiliary |
| wdata_i | input | 8 | Write data |
| stat_set_i | input | 8 | Status bits to set from the receive path |
| status_o | output | 8 | Channel status byte |
| rx_en_o | output | 1 | Receiver enabled |
| mode_rdata_o | output | 8 | Data from the last mode read |
| tx_stb_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| isr_set_o | output | 3 | Interrupt status set pulses: [0] tx ready, [1] rx ready, [2] break |
| isr_clr_o | output | 3 | Interrupt status clear pulses: [0] tx ready, [1] rx ready, [2] break of both channels |

## Verification
The hardest case to reach from the ports is a command clear and a receive-path set that land in the same cycle. This cycle decides both the precedence and whether a rise pulse is raised at all. Directed steps put a receive set in the same cycle as the receiver-reset and error-reset codes. Random steps then mix sparse set masks with command bytes whose upper nibble is biased toward the defined codes. The sticky mode pointer is also reached only through sequences of accesses, so the random traffic interleaves mode reads and writes with pointer-reset commands.

// File: rtl/uart_cmdreg_pkg.sv
package uart_cmdreg_pkg;

    localparam int REG_ADDR_W = 3;

    // Register window
    localparam logic [REG_ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_CLKSEL = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_CMD    = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_HOLD   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_AUX    = 3'd4;

    // Command codes in the upper nibble
    localparam logic [3:0] C_NOP     = 4'd0;
    localparam logic [3:0] C_PTR_RST = 4'd1;
    localparam logic [3:0] C_RX_RST  = 4'd2;
    localparam logic [3:0] C_TX_RST  = 4'd3;
    localparam logic [3:0] C_ERR_RST = 4'd4;
    localparam logic [3:0] C_BRK_RST = 4'd5;

    // Status byte positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMT = 3;
    localparam int ST_OVR   = 4;
    localparam int ST_BRK   = 7;

    // Interrupt pulse positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;
    localparam int IS_W   = 3;

    // Status bits the receive path may set
    localparam logic [7:0] RX_SET_MASK = 8'hF3;

    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_rst;
        logic mode_wr;
        logic mode_rd;
        logic hold_wr;
    } chan_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_cmdreg_pkg::*;
(
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [7:0]            cmd_i,
    output chan_act_t             act_o
);

    logic [3:0] code;

    always_comb begin
        code  = cmd_i[7:4];
        act_o = '0;
        if (wr_i) begin
            case (addr_i)
                A_MODE: act_o.mode_wr = 1'b1;
                A_CMD: begin
                    act_o.rx_on   = cmd_i[0];
                    act_o.rx_off  = cmd_i[1];
                    act_o.tx_on   = cmd_i[2];
                    act_o.tx_off  = cmd_i[3];
                    act_o.ptr_rst = (code == C_PTR_RST);
                    act_o.rx_rst  = (code == C_RX_RST);
                    act_o.tx_rst  = (code == C_TX_RST);
                    act_o.err_rst = (code == C_ERR_RST);
                    act_o.brk_rst = (code == C_BRK_RST);
                end
                A_HOLD: act_o.hold_wr = 1'b1;
                default: ;
            endcase
        end else if (rd_i && addr_i == A_MODE) begin
            act_o.mode_rd = 1'b1;
        end
    end

endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_wr_i,
    input  logic              mode_rd_i,
    input  logic              ptr_rst_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]             ptr;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } mode_st_t;

    mode_st_t   st_d, st_q;
    logic [DEPTH-1:0] ent_wr;
    logic             acc;

    assign acc = mode_wr_i | mode_rd_i;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign ent_wr[e] = mode_wr_i && (st_q.ptr == PTR_W'(e));
    end

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (ent_wr[e]) st_d.mem[e] = wdata_i;
        end
        if (mode_rd_i) st_d.rdata = st_q.mem[st_q.ptr];
        if (ptr_rst_i)
            st_d.ptr = '0;
        else if (acc && st_q.ptr != LAST)
            st_d.ptr = st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R9: after an access without a pointer reset the pointer rests on the last entry
    p_ptr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(acc) && !$past(ptr_rst_i) |-> st_q.ptr == LAST);

    // R9: a pointer reset returns to entry 0
    p_ptr_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ptr_rst_i) |-> st_q.ptr == '0);

endmodule

// File: rtl/uart_chan_status.sv
module uart_chan_status
    import uart_cmdreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_on_i,
    input  logic              rx_off_i,
    input  logic              tx_on_i,
    input  logic              tx_off_i,
    input  logic              rx_rst_i,
    input  logic              tx_rst_i,
    input  logic              err_rst_i,
    input  logic              brk_rst_i,
    input  logic              hold_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [7:0]        stat_set_i,
    output logic [7:0]        status_o,
    output logic              rx_en_o,
    output logic [IS_W-1:0]   isr_set_o,
    output logic [IS_W-1:0]   isr_clr_o,
    output logic              tx_stb_o,
    output logic [DATA_W-1:0] tx_data_o
);

    typedef struct packed {
        logic [7:0]        status;
        logic              rx_en;
        logic [IS_W-1:0]   iset;
        logic [IS_W-1:0]   iclr;
        logic              stb;
        logic [DATA_W-1:0] txd;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [7:0] s;

    always_comb begin
        st_d      = st_q;
        st_d.iset = '0;
        st_d.iclr = '0;
        st_d.stb  = 1'b0;

        // receive path events first, command clears override them
        s = st_q.status | (stat_set_i & RX_SET_MASK);

        if (rx_on_i)  st_d.rx_en = 1'b1;
        if (rx_off_i) st_d.rx_en = 1'b0;

        if (tx_on_i) begin
            s[ST_TXRDY] = 1'b1;
            s[ST_TXEMT] = 1'b1;
        end
        if (tx_off_i || tx_rst_i) begin
            s[ST_TXRDY] = 1'b0;
            s[ST_TXEMT] = 1'b0;
        end
        if (rx_rst_i) begin
            st_d.rx_en          = 1'b0;
            s[ST_RXRDY]         = 1'b0;
            st_d.iclr[IS_RX]    = 1'b1;
        end
        if (err_rst_i) s[ST_BRK:ST_OVR] = '0;
        if (brk_rst_i) st_d.iclr[IS_BRK] = 1'b1;

        st_d.iset[IS_TX]  = tx_on_i & ~tx_off_i & ~tx_rst_i;
        st_d.iclr[IS_TX]  = tx_off_i | tx_rst_i;
        st_d.iset[IS_RX]  = ~st_q.status[ST_RXRDY] & s[ST_RXRDY];
        st_d.iset[IS_BRK] = ~st_q.status[ST_BRK] & s[ST_BRK];

        if (hold_wr_i && st_q.status[ST_TXRDY]) begin
            st_d.stb = 1'b1;
            st_d.txd = wdata_i;
        end
        st_d.status = s;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign rx_en_o   = st_q.rx_en;
    assign isr_set_o = st_q.iset;
    assign isr_clr_o = st_q.iclr;
    assign tx_stb_o  = st_q.stb;
    assign tx_data_o = st_q.txd;

    p_tx_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[ST_TXRDY] == status_o[ST_TXEMT]);

    p_pulse_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (isr_set_o[IS_RX:IS_TX] & isr_clr_o[IS_RX:IS_TX]) == '0);

    p_rx_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rx_rst_i) |-> !rx_en_o && !status_o[ST_RXRDY]);

    p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(err_rst_i) |-> status_o[ST_BRK:ST_OVR] == '0);

    p_hold_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_stb_o |-> $past(status_o[ST_TXRDY]));

    p_tx_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(tx_rst_i) |-> !status_o[ST_TXRDY] && isr_clr_o[IS_TX]);

endmodule

// File: rtl/uart_chan_cmdreg.sv
module uart_chan_cmdreg
    import uart_cmdreg_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MODE_DEPTH = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [7:0]            stat_set_i,
    output logic [7:0]            status_o,
    output logic                  rx_en_o,
    output logic [DATA_W-1:0]     mode_rdata_o,
    output logic                  tx_stb_o,
    output logic [DATA_W-1:0]     tx_data_o,
    output logic [IS_W-1:0]       isr_set_o,
    output logic [IS_W-1:0]       isr_clr_o
);

    chan_act_t act;

    uart_cmd_decode u_dec (
        .wr_i   (wr_i),
        .rd_i   (rd_i),
        .addr_i (addr_i),
        .cmd_i  (wdata_i[7:0]),
        .act_o  (act)
    );

    uart_mode_regs #(
        .DATA_W (DATA_W),
        .DEPTH  (MODE_DEPTH)
    ) u_mode (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_wr_i (act.mode_wr),
        .mode_rd_i (act.mode_rd),
        .ptr_rst_i (act.ptr_rst),
        .wdata_i   (wdata_i),
        .rdata_o   (mode_rdata_o)
    );

    uart_chan_status #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_on_i    (act.rx_on),
        .rx_off_i   (act.rx_off),
        .tx_on_i    (act.tx_on),
        .tx_off_i   (act.tx_off),
        .rx_rst_i   (act.rx_rst),
        .tx_rst_i   (act.tx_rst),
        .err_rst_i  (act.err_rst),
        .brk_rst_i  (act.brk_rst),
        .hold_wr_i  (act.hold_wr),
        .wdata_i    (wdata_i),
        .stat_set_i (stat_set_i),
        .status_o   (status_o),
        .rx_en_o    (rx_en_o),
        .isr_set_o  (isr_set_o),
        .isr_clr_o  (isr_clr_o),
        .tx_stb_o   (tx_stb_o),
        .tx_data_o  (tx_data_o)
    );

    // R8: codes without an action leave the status byte alone unless bits 3:0 act
    p_nop_codes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_i && addr_i == A_CMD && wdata_i[3:0] == 4'h0 &&
              (wdata_i[7:4] == C_NOP || wdata_i[7:4] > C_BRK_RST) && stat_set_i == 8'h00)
        |-> status_o == $past(status_o));

    // R11: writes to ignored addresses leave the status byte alone
    p_ignored_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_i && (addr_i == A_CLKSEL || addr_i >= A_AUX) && stat_set_i == 8'h00)
        |-> status_o == $past(status_o) && !tx_stb_o);

endmodule

// File: tb/sim_uart_chan_cmdreg.sv
module sim_uart_chan_cmdreg;
    import uart_cmdreg_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, sset = '0;
    logic [7:0] status, rdata, txd;
    logic       rx_en, stb;
    logic [2:0] iset, iclr;

    always #2 clk = ~clk;

    uart_chan_cmdreg u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
        .wdata_i(wdata), .stat_set_i(sset), .status_o(status), .rx_en_o(rx_en),
        .mode_rdata_o(rdata), .tx_stb_o(stb), .tx_data_o(txd),
        .isr_set_o(iset), .isr_clr_o(iclr)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_stat = '0, m_rdata = '0, m_txd = '0;
    logic [7:0] m_mode [2];
    int         m_ptr = 0;
    logic       m_rx = 1'b0, m_stb = 1'b0;
    logic [2:0] m_iset = '0, m_iclr = '0;

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] f_cmd_status(logic [7:0] s, logic [7:0] cmd);
        logic [7:0] r = s;
        if (cmd[2]) r = r | 8'h0C;
        if (cmd[3] || cmd[7:4] == 4'd3) r = r & 8'hF3;
        if (cmd[7:4] == 4'd2) r = r & 8'hFE;
        if (cmd[7:4] == 4'd4) r = r & 8'h0F;
        return r;
    endfunction

    task automatic model(logic w, logic r, logic [2:0] a, logic [7:0] d, logic [7:0] st);
        logic [7:0] s0 = m_stat;
        logic [7:0] ns = m_stat | (st & 8'hF3);
        m_iset = '0; m_iclr = '0; m_stb = 1'b0;
        if (w) begin
            case (a)
                3'd0: begin m_mode[m_ptr] = d; m_ptr = 1; end
                3'd2: begin
                    if (d[0]) m_rx = 1'b1;
                    if (d[1]) m_rx = 1'b0;
                    if (d[7:4] == 4'd1) m_ptr = 0;
                    if (d[7:4] == 4'd2) begin m_rx = 1'b0; m_iclr[1] = 1'b1; end
                    if (d[7:4] == 4'd5) m_iclr[2] = 1'b1;
                    m_iset[0] = d[2] & ~d[3] & (d[7:4] != 4'd3);
                    m_iclr[0] = d[3] | (d[7:4] == 4'd3);
                    ns = f_cmd_status(ns, d);
                end
                3'd3: if (s0[2]) begin m_stb = 1'b1; m_txd = d; end
                default: ;
            endcase
        end else if (r && a == 3'd0) begin
            m_rdata = m_mode[m_ptr];
            m_ptr = 1;
        end
        m_iset[1] = ~s0[0] & ns[0];
        m_iset[2] = ~s0[7] & ns[7];
        m_stat = ns;
    endtask

    task automatic compare(string tag);
        chk(tag, "status", status, m_stat);
        chk(tag, "rx_en", {7'd0, rx_en}, {7'd0, m_rx});
        chk(tag, "mode_rdata", rdata, m_rdata);
        chk(tag, "isr_set", {5'd0, iset}, {5'd0, m_iset});
        chk(tag, "isr_clr", {5'd0, iclr}, {5'd0, m_iclr});
        chk(tag, "tx_stb", {7'd0, stb}, {7'd0, m_stb});
        if (m_stb) chk(tag, "tx_data", txd, m_txd);
    endtask

    task automatic step(string tag, logic w, logic r, logic [2:0] a, logic [7:0] d, logic [7:0] st);
        wr = w; rd = r; addr = a; wdata = d; sset = st;
        model(w, r, a, d, st);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; sset = '0;
        compare(tag);
    endtask

    initial begin
        m_mode[0] = '0; m_mode[1] = '0;
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        step("R1", 0, 1, 3'd0, 8'h00, 8'h00);            // entry 0 read, value 0
        // R9 pointer behaviour
        step("R9", 1, 0, 3'd2, 8'h10, 8'h00);
        step("R9", 1, 0, 3'd0, 8'hA5, 8'h00);
        step("R9", 1, 0, 3'd0, 8'h3C, 8'h00);
        step("R9", 1, 0, 3'd0, 8'h77, 8'h00);
        step("R9", 1, 0, 3'd2, 8'h10, 8'h00);
        step("R9", 0, 1, 3'd0, 8'h00, 8'h00);
        chk("R9", "first entry", rdata, 8'hA5);
        step("R9", 0, 1, 3'd0, 8'h00, 8'h00);
        chk("R9", "second entry", rdata, 8'h77);
        step("R9", 0, 0, 3'd0, 8'h00, 8'h00);
        // R2 receiver enable ordering
        step("R2", 1, 0, 3'd2, 8'h01, 8'h00);
        chk("R2", "rx on", {7'd0, rx_en}, 8'h01);
        step("R2", 1, 0, 3'd2, 8'h03, 8'h00);
        chk("R2", "both bits", {7'd0, rx_en}, 8'h00);
        // R3 transmitter
        step("R3", 1, 0, 3'd2, 8'h04, 8'h00);
        chk("R3", "tx on", status, 8'h0C);
        step("R3", 1, 0, 3'd2, 8'h0C, 8'h00);
        chk("R3", "both tx bits", status, 8'h00);
        // R10 holding gate
        step("R10", 1, 0, 3'd3, 8'h5A, 8'h00);
        step("R10", 1, 0, 3'd2, 8'h04, 8'h00);
        step("R10", 1, 0, 3'd3, 8'hC3, 8'h00);
        chk("R10", "forwarded", txd, 8'hC3);
        // R12 receive-path set
        step("R12", 0, 0, 3'd0, 8'h00, 8'hFF);
        chk("R12", "all set", status, 8'hFF);
        // R6 error reset
        step("R6", 1, 0, 3'd2, 8'h40, 8'h00);
        chk("R6", "errors cleared", status, 8'h0F);
        // R4 receiver reset beats enable bit
        step("R4", 1, 0, 3'd2, 8'h21, 8'h00);
        // R5 transmitter reset, also with enable bit
        step("R5", 1, 0, 3'd2, 8'h30, 8'h00);
        step("R5", 1, 0, 3'd2, 8'h34, 8'h00);
        chk("R5", "stays off", status & 8'h0C, 8'h00);
        // R7 break interrupt reset
        step("R12", 0, 0, 3'd0, 8'h00, 8'h80);
        step("R7", 1, 0, 3'd2, 8'h50, 8'h00);
        // R8 inert codes
        for (int c = 6; c < 16; c++) step("R8", 1, 0, 3'd2, 8'(c << 4), 8'h00);
        step("R8", 1, 0, 3'd2, 8'h00, 8'h00);
        // R11 ignored addresses and reads
        step("R11", 1, 0, 3'd1, 8'hFF, 8'h00);
        step("R11", 1, 0, 3'd4, 8'hFF, 8'h00);
        for (int a = 5; a < 8; a++) step("R11", 1, 0, 3'(a), 8'hFF, 8'h00);
        step("R11", 0, 1, 3'd2, 8'h00, 8'h00);
        step("R11", 0, 1, 3'd3, 8'h00, 8'h00);
        // R12 masked bits and same-cycle collisions
        step("R12", 0, 0, 3'd0, 8'h00, 8'h0C);
        chk("R12", "tx bits ignored", status & 8'h0C, 8'h00);
        step("R12", 1, 0, 3'd2, 8'h20, 8'h01);
        chk("R12", "reset wins", status & 8'h01, 8'h00);
        step("R12", 1, 0, 3'd2, 8'h40, 8'hF0);
        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a = 3'($urandom % 6);
            logic [7:0] d = 8'($urandom);
            logic [7:0] st = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            logic       w = ($urandom % 3 != 0);
            logic       r = ($urandom % 2 == 0);
            if (a == 3'd2 && ($urandom % 2 == 0)) d[7:4] = 4'($urandom % 6);
            step("rand", w, r, a, d, st);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule